// File: doc/BRIEF.md
# DMA channel register access guard

This block is the register-access front end of a multi-channel DMA controller. It sits between a simple request/response register bus and the per-channel parameter registers: source address, destination address, configuration, microblock length and next-descriptor address. It also holds the controller-wide fields that belong to individual channels: the enable state of every channel and the secure/non-secure attribute of every channel. Each bus request carries a secure attribute. The guard decides, for every access, whether a write commits and whether a read returns the stored value or zero.

A channel's parameter registers are frozen while that channel is enabled. The enable-set and enable-clear controls stay writable, so a running channel can always be stopped. A non-secure request cannot modify anything that belongs to a secure channel, and reads of such state by a non-secure request return zero. Filtered accesses are answered exactly like normal ones and raise no error. Software therefore cannot learn which channels are secure from the bus response.

The bus side is pipelined. Any cycle may carry a request, and its response appears one cycle later. A small state machine records what the response slot holds:
- `ST_IDLE`: no response is pending.
- `ST_RDATA`: read data is being returned.
- `ST_WACK`: a write acknowledge is being returned.

From any state the machine moves to `ST_RDATA` on a read request, to `ST_WACK` on a write request, and to `ST_IDLE` when no request is present.

Address map. Address bit 5 selects the global space when it is 1. In channel space, bits [4:3] hold the channel and bits [2:0] hold the register index:
- 0: source address
- 1: destination address
- 2: configuration
- 3: microblock length
- 4: next-descriptor address
- 5 to 7: reserved

In global space, bits [2:0] select the register:
- 0: enable status (read)
- 1: enable set, write 1s
- 2: enable clear, write 1s
- 3: secure mask

In every global register, bit i belongs to channel i.

Top module: `dma_reg_guard`

## Requirements
- R1: After reset every channel parameter register reads 0. The enable status reads 0. The secure mask reads all ones, meaning every channel is secure. No response is pending.
- R2: Every request, read or write, filtered or not, is answered by resp_valid high in the cycle after it is accepted. resp_valid is low in the cycle after a cycle with no request. There is no error indication.
- R3: Each channel's secure bit is independent. Only a secure write to the secure mask (global index 3) changes it. A non-secure write to that register leaves the mask unchanged.
- R4: A write to a parameter register of an enabled channel has no effect, whatever the request's attribute.
- R5: A non-secure write to a parameter register of a secure channel has no effect.
- R6: A non-secure read of a secure channel's parameter register returns 0. A secure read of the same register returns its stored value.
- R7: For a non-secure request, the bits of secure channels read as 0 in the enable status and in the secure mask, and those bits are ignored in writes to enable set and enable clear.
- R8: Enable set and enable clear take effect for a channel even while it is enabled. Enable set ORs in the written 1s, and enable clear removes them.
- R9: Reserved channel register indices 5 to 7 read 0. Writes to them change no register.
- R10: A write to a parameter register of a disabled channel commits when the request is secure or the channel is non-secure. It then reads back unchanged, and write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Request issued by secure software |
| req_addr | input | 6 | Register address (map above) |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_data | output | 32 | Read data, or 0 for a write or filtered read |

## Verification
Each result is due at a fixed point:
- A write, committed or filtered, updates state at the same clock edge that accepts it.
- The response for a request, with its read data, is registered at that edge and is valid for the whole following cycle.

The bench drives each request at a falling edge and samples resp_valid and resp_data at the next falling edge, half a cycle after the accepting edge. The effect of a write is judged only by a later read. A back-to-back pair of requests checks that each response comes exactly one cycle after its own request and never lags further behind.

// File: rtl/dma_guard_pkg.sv
package dma_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDATA = 2'd1,
        ST_WACK  = 2'd2
    } guard_state_e;

    // register index field width inside one channel or the global space
    localparam int unsigned IDX_W    = 3;
    // number of implemented parameter registers per channel
    localparam int unsigned CH_REGS  = 5;

    localparam logic [IDX_W-1:0] G_STAT    = 3'd0;
    localparam logic [IDX_W-1:0] G_ENSET   = 3'd1;
    localparam logic [IDX_W-1:0] G_ENCLR   = 3'd2;
    localparam logic [IDX_W-1:0] G_SECMASK = 3'd3;

endpackage

// File: rtl/dma_guard_decode.sv
module dma_guard_decode
    import dma_guard_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CH_W   = 2,
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_global,
    output logic [CH_W-1:0]   ch,
    output logic [IDX_W-1:0]  idx,
    output logic              ch_reg_hit
);

    always_comb begin
        is_global  = addr[ADDR_W-1];
        ch         = addr[ADDR_W-2 -: CH_W];
        idx        = addr[IDX_W-1:0];
        ch_reg_hit = !is_global
                     && (int'(idx) < int'(CH_REGS))
                     && (int'(ch) < int'(NUM_CH));
    end

endmodule

// File: rtl/dma_guard_ctrl.sv
module dma_guard_ctrl #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              sec_wr,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] acc_mask,
    output logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] sec_q
);

    logic [NUM_CH-1:0] eff_bits;

    always_comb eff_bits = wbits & acc_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_set) begin
            en_q <= en_q | eff_bits;
        end else if (en_clr) begin
            en_q <= en_q & ~eff_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '1;
        end else if (sec_wr) begin
            sec_q <= wbits;
        end
    end

endmodule

// File: rtl/dma_guard_chregs.sv
module dma_guard_chregs
    import dma_guard_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CH_W   = 2,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned FLAT_W = NUM_CH * CH_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CH_W-1:0]   ch,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [FLAT_W-1:0] regs_flat
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar r = 0; r < CH_REGS; r++) begin : g_reg
            logic [DATA_W-1:0] q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && (ch == CH_W'(c)) && (idx == IDX_W'(r))) begin
                    q <= wdata;
                end
            end

            assign regs_flat[(c*CH_REGS + r)*DATA_W +: DATA_W] = q;
        end
    end

endmodule

// File: rtl/dma_reg_guard.sv
module dma_reg_guard
    import dma_guard_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ADDR_W = 1 + CH_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data
);

    localparam int unsigned FLAT_W = NUM_CH * CH_REGS * DATA_W;

    guard_state_e      state_q, state_d;
    logic              is_global, ch_reg_hit;
    logic [CH_W-1:0]   ch;
    logic [IDX_W-1:0]  idx;
    logic [NUM_CH-1:0] en_q, sec_q, acc_mask;
    logic [FLAT_W-1:0] regs_flat;
    logic              ch_we, g_wr;
    logic [DATA_W-1:0] rd_val, rdata_q;

    dma_guard_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .addr       (req_addr),
        .is_global  (is_global),
        .ch         (ch),
        .idx        (idx),
        .ch_reg_hit (ch_reg_hit)
    );

    // a non-secure request only reaches channels that are non-secure
    always_comb acc_mask = req_secure ? {NUM_CH{1'b1}} : ~sec_q;

    always_comb begin
        g_wr  = req_valid && req_write && is_global;
        ch_we = req_valid && req_write && ch_reg_hit
                && !en_q[ch] && (req_secure || !sec_q[ch]);
    end

    dma_guard_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set   (g_wr && (idx == G_ENSET)),
        .en_clr   (g_wr && (idx == G_ENCLR)),
        .sec_wr   (g_wr && (idx == G_SECMASK) && req_secure),
        .wbits    (req_wdata[NUM_CH-1:0]),
        .acc_mask (acc_mask),
        .en_q     (en_q),
        .sec_q    (sec_q)
    );

    dma_guard_chregs #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ch_we),
        .ch        (ch),
        .idx       (idx),
        .wdata     (req_wdata),
        .regs_flat (regs_flat)
    );

    // read value as seen by the requester
    always_comb begin
        rd_val = '0;
        if (is_global) begin
            if (idx == G_STAT) begin
                rd_val[NUM_CH-1:0] = en_q & acc_mask;
            end else if (idx == G_SECMASK) begin
                rd_val[NUM_CH-1:0] = sec_q & acc_mask;
            end
        end else if (ch_reg_hit && (req_secure || !sec_q[ch])) begin
            rd_val = regs_flat[(int'(ch)*CH_REGS + int'(idx))*DATA_W +: DATA_W];
        end
    end

    // next state of the response slot
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (req_write) begin
            state_d = ST_WACK;
        end else begin
            state_d = ST_RDATA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (req_valid && !req_write) ? rd_val : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                resp_valid = 1'b0;
                resp_data  = '0;
            end
            ST_RDATA: begin
                resp_valid = 1'b1;
                resp_data  = rdata_q;
            end
            ST_WACK: begin
                resp_valid = 1'b1;
                resp_data  = '0;
            end
            default: begin
                resp_valid = 1'b0;
                resp_data  = '0;
            end
        endcase
    end

endmodule

// File: rtl/dma_guard_chk.sv
module dma_guard_chk
    import dma_guard_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ADDR_W = 1 + CH_W + IDX_W,
    localparam int unsigned FLAT_W = NUM_CH * CH_REGS * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_secure,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic [DATA_W-1:0] resp_data,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] sec_q,
    input logic [FLAT_W-1:0] regs_flat
);

    logic            a_global, a_reserved;
    logic [CH_W-1:0] a_ch;

    always_comb begin
        a_global   = req_addr[ADDR_W-1];
        a_ch       = req_addr[ADDR_W-2 -: CH_W];
        a_reserved = !a_global && (int'(req_addr[IDX_W-1:0]) >= int'(CH_REGS));
    end

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    assert_no_resp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    assert_sec_mask_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure) |=> $stable(sec_q));

    assert_enabled_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !a_global && en_q[a_ch]) |=> $stable(regs_flat));

    assert_nonsec_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure && !a_global && sec_q[a_ch])
        |=> $stable(regs_flat));

    assert_nonsec_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_secure && !a_global && sec_q[a_ch])
        |=> (resp_data == '0));

    assert_reserved_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_reserved) |=> ($stable(regs_flat) && (resp_data == '0)));

endmodule

bind dma_reg_guard dma_guard_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .en_q       (en_q),
    .sec_q      (sec_q),
    .regs_flat  (regs_flat)
);

// File: tb/dma_reg_guard_bench.sv
`timescale 1ns/1ps
module dma_reg_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic [31:0] resp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_reg_guard u_dma_reg_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_secure (req_secure),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_data  (resp_data)
    );

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic [5:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 44;
    // addr: ch c reg r = {0,c,r}; globals 0x20 stat, 0x21 set, 0x22 clear, 0x23 secure mask
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 6'h23, 32'h0,        32'hF,        4'd1},  // R1 all secure
        '{1'b0, 1'b1, 6'h00, 32'h0,        32'h0,        4'd1},  // R1 regs zero
        '{1'b0, 1'b1, 6'h20, 32'h0,        32'h0,        4'd1},  // R1 none enabled
        '{1'b1, 1'b1, 6'h23, 32'h5,        32'h0,        4'd3},  // R3 ch0,ch2 secure
        '{1'b0, 1'b1, 6'h23, 32'h0,        32'h5,        4'd3},
        '{1'b1, 1'b0, 6'h23, 32'hF,        32'h0,        4'd3},  // R3 non-secure ignored
        '{1'b0, 1'b1, 6'h23, 32'h0,        32'h5,        4'd3},
        '{1'b0, 1'b0, 6'h23, 32'h0,        32'h0,        4'd7},  // R7 mask hidden
        '{1'b1, 1'b0, 6'h08, 32'h11111111, 32'h0,        4'd10}, // R10
        '{1'b0, 1'b0, 6'h08, 32'h0,        32'h11111111, 4'd10},
        '{1'b1, 1'b0, 6'h01, 32'hDEADBEEF, 32'h0,        4'd5},  // R5 blocked
        '{1'b0, 1'b1, 6'h01, 32'h0,        32'h0,        4'd5},
        '{1'b1, 1'b1, 6'h01, 32'hCAFE0001, 32'h0,        4'd10},
        '{1'b0, 1'b0, 6'h01, 32'h0,        32'h0,        4'd6},  // R6 reads zero
        '{1'b0, 1'b1, 6'h01, 32'h0,        32'hCAFE0001, 4'd6},
        '{1'b1, 1'b1, 6'h1C, 32'h33330004, 32'h0,        4'd10},
        '{1'b0, 1'b0, 6'h1C, 32'h0,        32'h33330004, 4'd10},
        '{1'b1, 1'b0, 6'h21, 32'hF,        32'h0,        4'd7},  // R7 only ch1,ch3
        '{1'b0, 1'b1, 6'h20, 32'h0,        32'hA,        4'd7},
        '{1'b0, 1'b0, 6'h20, 32'h0,        32'hA,        4'd7},
        '{1'b1, 1'b1, 6'h08, 32'h22222222, 32'h0,        4'd4},  // R4 locked
        '{1'b0, 1'b1, 6'h08, 32'h0,        32'h11111111, 4'd4},
        '{1'b1, 1'b0, 6'h1A, 32'h77,       32'h0,        4'd4},
        '{1'b0, 1'b0, 6'h1A, 32'h0,        32'h0,        4'd4},
        '{1'b1, 1'b1, 6'h21, 32'h1,        32'h0,        4'd8},  // R8 set while running
        '{1'b0, 1'b1, 6'h20, 32'h0,        32'hB,        4'd8},
        '{1'b0, 1'b0, 6'h20, 32'h0,        32'hA,        4'd7},
        '{1'b1, 1'b0, 6'h22, 32'hF,        32'h0,        4'd7},  // R7 clear ch1,ch3 only
        '{1'b0, 1'b1, 6'h20, 32'h0,        32'h1,        4'd8},
        '{1'b1, 1'b1, 6'h03, 32'h5,        32'h0,        4'd4},
        '{1'b0, 1'b1, 6'h03, 32'h0,        32'h0,        4'd4},
        '{1'b1, 1'b1, 6'h22, 32'h1,        32'h0,        4'd8},  // R8 stop ch0
        '{1'b0, 1'b1, 6'h20, 32'h0,        32'h0,        4'd8},
        '{1'b1, 1'b1, 6'h03, 32'hABC,      32'h0,        4'd10},
        '{1'b0, 1'b1, 6'h03, 32'h0,        32'hABC,      4'd10},
        '{1'b1, 1'b1, 6'h0D, 32'hFFFF,     32'h0,        4'd9},  // R9 reserved
        '{1'b0, 1'b1, 6'h0D, 32'h0,        32'h0,        4'd9},
        '{1'b0, 1'b1, 6'h08, 32'h0,        32'h11111111, 4'd9},
        '{1'b1, 1'b1, 6'h08, 32'h22222222, 32'h0,        4'd10},
        '{1'b0, 1'b0, 6'h08, 32'h0,        32'h22222222, 4'd10},
        '{1'b1, 1'b1, 6'h23, 32'h2,        32'h0,        4'd3},  // R3 only ch1 secure
        '{1'b0, 1'b0, 6'h08, 32'h0,        32'h0,        4'd6},
        '{1'b0, 1'b0, 6'h01, 32'h0,        32'hCAFE0001, 4'd3},
        '{1'b0, 1'b0, 6'h23, 32'h0,        32'h0,        4'd7}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input int req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the response
    task automatic access(input logic wr, input logic sec, input logic [5:0] a,
                          input logic [31:0] wd, input logic [31:0] exp, input int req);
        req_valid  = 1'b1;
        req_write  = wr;
        req_secure = sec;
        req_addr   = a;
        req_wdata  = wd;
        @(posedge clk);
        @(negedge clk);
        check({31'b0, resp_valid}, 32'h1, 2, "resp_valid after request");
        check(resp_data, wr ? 32'h0 : exp, req, $sformatf("addr %h", a));
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        check({31'b0, resp_valid}, 32'h0, 1, "no response after reset"); // R1

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].sec, VECS[i].addr, VECS[i].wd,
                   VECS[i].exp, int'(VECS[i].req));
        end

        // R2 back-to-back requests, each answered one cycle later
        req_valid = 1'b1; req_write = 1'b0; req_secure = 1'b1; req_addr = 6'h23;
        @(posedge clk); @(negedge clk);
        check({31'b0, resp_valid}, 32'h1, 2, "first of pair valid");
        check(resp_data, 32'h2, 2, "first of pair data");
        req_addr = 6'h08;
        @(posedge clk); @(negedge clk);
        check({31'b0, resp_valid}, 32'h1, 2, "second of pair valid");
        check(resp_data, 32'h22222222, 2, "second of pair data");
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check({31'b0, resp_valid}, 32'h0, 2, "idle after pair");

        // R1 reset in the middle of a run
        do_reset();
        check({31'b0, resp_valid}, 32'h0, 1, "no response after second reset");
        access(1'b0, 1'b1, 6'h23, 32'h0, 32'hF, 1);
        access(1'b0, 1'b1, 6'h08, 32'h0, 32'h0, 1);
        access(1'b0, 1'b1, 6'h03, 32'h0, 32'h0, 1);
        access(1'b0, 1'b1, 6'h20, 32'h0, 32'h0, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule